// File: doc/BRIEF.md
# Horizontal Pixel-Stream Window Clipper

This block sits in a display channel between the framebuffer reader and the next processing stage. Pixels arrive one per handshake, line by line, with a start-of-line flag on the first pixel of each line and an end-of-frame flag on the very last pixel of the frame. The block drops a programmable number of pixels at the left and right of every line, so only a horizontal window of the source line continues downstream. Lines are never removed: every input line gives an output line.

Settings come in as two packed size words plus a bypass bit. They are captured into a shadow copy only when the end-of-frame pixel is accepted, and only if the reload-disable input is low at that moment, so a frame is always processed with one consistent setting. The datapath is a pass-through with no storage: kept pixels appear on the output in the same cycle, and dropped pixels are taken from the input without waiting for the consumer.

Top module: `hclip_stream`

## Requirements
- R1: After reset the shadow settings are in bypass, out_valid is low while in_valid is low, and in_ready follows out_ready.
- R2: With the active bypass bit set, every pixel leaves unchanged, with its data, start-of-line and end-of-frame flags, whatever the size fields hold.
- R3: cfg_size0 carries source width minus one in bits [31:16] and line count minus one in bits [15:0]; cfg_size1 carries the left clip count in bits [31:16] and the right field in bits [15:0], equal to source width minus (left clip plus window width) minus one, modulo 2^16 (all ones for a window that ends at the last column).
- R4: Out of bypass, pixels whose column index is below the left clip or above width minus one minus the right field minus one are dropped; all others are forwarded in input order.
- R5: The first kept pixel of each line carries out_sol; the column count restarts at every in_sol, so each input line gives exactly one output line.
- R6: While out_valid is high and out_ready is low, in_ready is low and the output pixel is held.
- R7: New settings take effect only after the end-of-frame pixel is accepted; changes during a frame do not affect that frame.
- R8: When cfg_reload_dis is high as the end-of-frame pixel is accepted, the previous settings stay active for the next frame.
- R9: Out of bypass, out_eof is raised on the last kept pixel of the line whose index equals the programmed line count minus one.
- R10: A dropped pixel is accepted (in_ready high, out_valid low) even while out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size0 | input | 2*DIM_W | Width minus one (upper half), lines minus one (lower half) |
| cfg_size1 | input | 2*DIM_W | Left clip (upper half), right field (lower half) |
| cfg_bypass | input | 1 | Pass-through request, captured at frame end |
| cfg_reload_dis | input | 1 | Blocks the frame-end capture of settings |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | PIX_W | Input pixel |
| in_sol | input | 1 | First pixel of a line |
| in_eof | input | 1 | Last pixel of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | PIX_W | Output pixel |
| out_sol | output | 1 | First kept pixel of a line |
| out_eof | output | 1 | Last kept pixel of a frame |

## Verification
The assertions assume in_valid, in_data and the flags stay steady while a pixel waits, that in_sol marks every line start, and that in_eof comes with the last pixel of a frame whose line count matches the active setting. The bench drives each pixel until it sees in_ready at the falling edge, starts every line with in_sol and flags end of frame only on the last pixel. Settings are changed only between frames, except in the scenario that deliberately changes them mid-frame to probe the shadow capture.

// File: rtl/hclip_stream.sv
module hclip_stream #(
  parameter int PIX_W = 24,
  parameter int DIM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*DIM_W-1:0] cfg_size0,
  input  logic [2*DIM_W-1:0] cfg_size1,
  input  logic               cfg_bypass,
  input  logic               cfg_reload_dis,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_data,
  input  logic               in_sol,
  input  logic               in_eof,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_data,
  output logic               out_sol,
  output logic               out_eof
);
  localparam int HI = 2*DIM_W-1;
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  logic [DIM_W-1:0] w_m1_q, h_m1_q, left_q, rfld_q;
  logic             byp_q;
  logic [DIM_W-1:0] col_q, line_q;
  logic             fstart_q;

  logic [DIM_W-1:0] col, cur_line, last_col;
  logic             keep, acc, load;

  assign col      = in_sol ? '0 : col_q;
  assign cur_line = in_sol ? (fstart_q ? '0 : line_q + ONE) : line_q;
  assign last_col = w_m1_q - rfld_q - ONE;
  assign keep     = byp_q || ((col >= left_q) && (col <= last_col));

  assign out_valid = in_valid && keep;
  assign in_ready  = out_ready || !keep;
  assign out_data  = in_data;
  assign out_sol   = byp_q ? in_sol : (col == left_q);
  assign out_eof   = byp_q ? in_eof : ((col == last_col) && (cur_line == h_m1_q));

  assign acc  = in_valid && in_ready;
  assign load = acc && in_eof && !cfg_reload_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q    <= '0;
      line_q   <= '0;
      fstart_q <= 1'b1;
    end else if (acc) begin
      col_q    <= col + ONE;
      line_q   <= cur_line;
      fstart_q <= in_eof;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_q  <= 1'b1;
      w_m1_q <= '0;
      h_m1_q <= '0;
      left_q <= '0;
      rfld_q <= '0;
    end else if (load) begin
      byp_q  <= cfg_bypass;
      w_m1_q <= cfg_size0[HI:DIM_W];
      h_m1_q <= cfg_size0[DIM_W-1:0];
      left_q <= cfg_size1[HI:DIM_W];
      rfld_q <= cfg_size1[DIM_W-1:0];
    end
  end

  // R2: in bypass every offered pixel reaches the output unchanged
  p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q && in_valid) |-> (out_valid && out_data == in_data && out_sol == in_sol && out_eof == in_eof));

  // R6: a stalled output blocks the input and holds the pixel
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: no output pixel without an input pixel
  p_no_invented_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  // R7: shadow settings move only after an accepted frame end
  p_shadow_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready && in_eof) |->
      ($stable(left_q) && $stable(rfld_q) && $stable(w_m1_q) && $stable(byp_q)));

  // R8: reload disabled at frame end keeps the old settings
  p_reload_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && in_eof && cfg_reload_dis) |->
      ($stable(left_q) && $stable(rfld_q) && $stable(h_m1_q) && $stable(byp_q)));

  // R10: dropped pixels never wait on the consumer
  p_drop_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> in_ready);
endmodule

// File: tb/test_hclip_stream.sv
module test_hclip_stream;
  localparam int PIX_W = 24;
  localparam int DIM_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*DIM_W-1:0] cfg_size0 = '0, cfg_size1 = '0;
  logic cfg_bypass = 1'b0, cfg_reload_dis = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_eof = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_sol, out_eof;
  logic [PIX_W-1:0] out_data;
  logic out_ready = 1'b1;

  int checks = 0, errors = 0;
  int stall_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  int cap_n = 0;
  logic [PIX_W-1:0] cap_d [0:255];
  logic cap_s [0:255];
  logic cap_e [0:255];
  int stall_bad = 0;
  bit done = 0;

  logic [2*DIM_W-1:0] pend_s0, pend_s1;
  logic pend_byp;

  always #4 clk = ~clk;

  hclip_stream #(.PIX_W(PIX_W), .DIM_W(DIM_W)) i_hclip_stream (
    .clk(clk), .rst_n(rst_n), .cfg_size0(cfg_size0), .cfg_size1(cfg_size1),
    .cfg_bypass(cfg_bypass), .cfg_reload_dis(cfg_reload_dis),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sol(in_sol), .in_eof(in_eof), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sol(out_sol), .out_eof(out_eof));

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (stall_mode == 0) out_ready = 1'b1;
    else if (stall_mode == 1) out_ready = lfsr[0];
    else out_ready = 1'b0;
  end

  initial forever begin
    @(negedge clk);
    if (out_valid && !out_ready && in_ready) stall_bad++;
    if (out_valid && out_ready && cap_n < 256) begin
      cap_d[cap_n] = out_data; cap_s[cap_n] = out_sol; cap_e[cap_n] = out_eof;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, input int h, input int x, input int ww, input bit byp);
    pend_s0  = {DIM_W'(w-1), DIM_W'(h-1)};
    pend_s1  = {DIM_W'(x), DIM_W'(w-x-ww-1)};
    pend_byp = byp;
  endtask

  task automatic apply_cfg();
    cfg_size0 = pend_s0; cfg_size1 = pend_s1; cfg_bypass = pend_byp;
  endtask

  task automatic send_px(input int l, input int c, input bit sol, input bit eof);
    in_valid = 1'b1; in_data = PIX_W'(l*256 + c); in_sol = sol; in_eof = eof;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sol = 1'b0; in_eof = 1'b0;
  endtask

  // sends a w x h frame starting from pixel index skip; expects columns first..last kept
  task automatic run_frame(input int w, input int h, input int first, input int last,
                           input int mid_apply, input int skip, input string req);
    int n, k;
    int idx = 0;
    if (skip == 0) cap_n = 0;
    for (int l = 0; l < h; l++)
      for (int c = 0; c < w; c++) begin
        if (idx == mid_apply) apply_cfg();
        if (idx >= skip) send_px(l, c, c == 0, (l == h-1) && (c == w-1));
        idx++;
      end
    repeat (2) @(posedge clk); #1;
    n = h * (last - first + 1);
    chk(cap_n == n, req, cap_n, n);
    k = 0;
    for (int l = 0; l < h; l++)
      for (int c = first; c <= last; c++) begin
        if (k < cap_n) begin
          chk(cap_d[k] == PIX_W'(l*256 + c), req, int'(cap_d[k]), l*256 + c);
          chk(cap_s[k] == (c == first), {req, " sol"}, cap_s[k], c == first);
          chk(cap_e[k] == ((l == h-1) && (c == last)), {req, " eof"}, cap_e[k],
              (l == h-1) && (c == last));
        end
        k++;
      end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == out_ready, "R1 in_ready", in_ready, out_ready);
  endtask

  task automatic t_default_bypass();
    set_cfg(8, 3, 2, 4, 1'b0); apply_cfg();
    run_frame(3, 2, 0, 2, -1, 0, "R1 R2 default bypass");
  endtask

  task automatic t_clip();
    run_frame(8, 3, 2, 5, -1, 0, "R3 R4 R5 R9 clip");
  endtask

  task automatic t_backpressure();
    stall_bad = 0; stall_mode = 1;
    run_frame(8, 3, 2, 5, -1, 0, "R6 backpressure");
    stall_mode = 0;
    chk(stall_bad == 0, "R6 in_ready during stall", stall_bad, 0);
  endtask

  task automatic t_drop_ready();
    cap_n = 0; stall_mode = 2; @(posedge clk); #1;
    in_valid = 1'b1; in_data = 0; in_sol = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R10 drop col0 accepted", in_ready, 1);
    @(posedge clk); #1; in_sol = 1'b0; in_data = 1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R10 drop col1 accepted", in_ready, 1);
    @(posedge clk); #1; in_data = 2;
    @(negedge clk);
    chk(!in_ready && out_valid, "R6 kept col2 stalls", in_ready, 0);
    in_valid = 1'b0; stall_mode = 0;
    @(posedge clk); #1;
    run_frame(8, 3, 2, 5, -1, 2, "R10 frame after drop");
  endtask

  task automatic t_shadow();
    set_cfg(8, 3, 0, 3, 1'b0);
    run_frame(8, 3, 2, 5, 5, 0, "R7 mid-frame change ignored");
    run_frame(8, 3, 0, 2, -1, 0, "R7 change applied next frame");
  endtask

  task automatic t_hold();
    cfg_reload_dis = 1'b1;
    set_cfg(8, 3, 1, 6, 1'b0); apply_cfg();
    run_frame(8, 3, 0, 2, -1, 0, "R8 current frame");
    run_frame(8, 3, 0, 2, -1, 0, "R8 reload disabled");
    cfg_reload_dis = 1'b0;
    run_frame(8, 3, 0, 2, -1, 0, "R8 reload reenabled");
    run_frame(8, 3, 1, 6, -1, 0, "R8 new setting");
  endtask

  task automatic t_right_edge();
    set_cfg(6, 2, 5, 1, 1'b0); apply_cfg();
    run_frame(8, 3, 1, 6, -1, 0, "R3 load edge window");
    run_frame(6, 2, 5, 5, -1, 0, "R3 wrapped right field");
  endtask

  task automatic t_cfg_bypass();
    set_cfg(5, 2, 1, 2, 1'b1); apply_cfg();
    run_frame(6, 2, 5, 5, -1, 0, "R2 load bypass");
    stall_mode = 1;
    run_frame(5, 2, 0, 4, -1, 0, "R2 programmed bypass");
    stall_mode = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_bypass();
    t_clip();
    t_backpressure();
    t_drop_ready();
    t_shadow();
    t_hold();
    t_right_edge();
    t_cfg_bypass();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule